// File: doc/BRIEF.md
# Camera Pixel Mapper with Region-of-Interest Crop

This block sits directly behind a camera link deserializer. On each clock it takes 24 bits of port data and three qualifiers: frame active, line active and data present. It emits at most one 32-bit output word per clock, together with a valid strobe. A run-time mode selects how the 24 port bits split into pixels: one, two or three 8-bit pixels, or one pixel of up to 16 bits. Clocks that do not carry data are dropped. Frame and line starts are found from the rising edges of the frame and line qualifiers.

A region-of-interest window is set by three settings: lines kept per frame, pixels kept per line, and significant bits per pixel. Lines and pixels beyond the window are discarded. Each kept pixel is masked down to its significant bits. The window and the mode are latched only when a frame starts, so software can retarget them between frames without tearing a frame.

Each output word carries the packed pixels in the low 24 bits. Above them sit a start-of-frame flag, an end-of-line flag, the number of pixels in the word, and the low nibble of the line number within the frame.

Top module: `pix_mapper`

## Requirements
- R1: While reset is held and after it, out_valid is 0 and out_word is 0 until a qualifying input clock arrives.
- R2: An output word appears exactly one clock after an input clock with frame, line and data qualifiers all high. Any clock with one of them low produces no word.
- R3: Mode encoding: 0 is one 8-bit pixel (port[7:0]), 1 is two 8-bit pixels (port[15:0]), 2 is three 8-bit pixels (port[23:0]), and 3 is one 16-bit pixel (port[15:0]). Pixel k occupies word bits [8k+7:8k], and the 16-bit pixel occupies bits [15:0]. Unused data bits are 0. Word bits [27:26] hold the pixel count (1 to 3).
- R4: Each pixel keeps only its low roi_bits bits. A value of roi_bits at or above the pixel width keeps the whole pixel, and 0 clears it.
- R5: Only the first roi_pixels pixels of each line are output. A clock that straddles the limit emits only the pixels up to the limit, with a reduced count. Later clocks in that line emit nothing.
- R6: Lines whose 0-based index within the frame is roi_lines or higher emit nothing.
- R7: Word bit 24 (start of frame) is 1 only on the first word output in each frame, even when that word comes after clocks without data.
- R8: Word bit 25 (end of line) is 1 on the word that holds pixel number roi_pixels of a line.
- R9: Word bits [31:28] hold the low four bits of the 0-based line index. Lines are counted on rising edges of the line qualifier inside a frame.
- R10: roi_lines, roi_pixels, roi_bits and cfg_mode are sampled only at the rising edge of the frame qualifier. Changes during a frame take effect from the next frame.
- R11: The line count restarts at 0 at each frame start, and the pixel count restarts at each line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_data | input | 24 | Three 8-bit port lanes, lane 0 in bits [7:0] |
| fval | input | 1 | Frame interval qualifier |
| lval | input | 1 | Line interval qualifier |
| dval | input | 1 | Data-present qualifier |
| cfg_mode | input | 2 | Pixel layout mode (R3) |
| roi_lines | input | 12 | Lines kept per frame |
| roi_pixels | input | 12 | Pixels kept per line |
| roi_bits | input | 5 | Significant bits per pixel |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 32 | Packed pixels and position markers |

## Verification
Several properties hold on every cycle and are checked continuously:
- A word is never emitted without all three qualifiers high on the previous clock.
- A word's pixel count is never zero.
- A single-pixel word has a clear upper lane.
- A word produced in the frame-start clock carries the start flag.
- After an end-of-line word, no further word comes in the same line.
- The latched window holds steady outside frame starts.

Some behaviour can only be shown by the bench's scenarios: the exact packing and masking per mode, where the crop falls within a straddling clock, the line numbering and the line-count cutoff, and the deferral of a mid-frame setting change.

// File: rtl/pm_pkg.sv
// Shared definitions for the pixel mapper: port geometry and the layout
// modes. Assumes a 24-bit port made of three 8-bit lanes.
package pm_pkg;

    localparam int PORT_W = 24;
    localparam int LANE_W = 8;
    localparam int LANES  = PORT_W / LANE_W;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        PM_ONE8   = 2'd0,
        PM_TWO8   = 2'd1,
        PM_THREE8 = 2'd2,
        PM_ONE16  = 2'd3
    } pm_mode_e;

    // Pixels delivered by one data clock in a given mode.
    function automatic logic [1:0] beat_pixels(input logic [1:0] mode);
        case (mode)
            PM_TWO8:   beat_pixels = 2'd2;
            PM_THREE8: beat_pixels = 2'd3;
            default:   beat_pixels = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/pm_roi_shadow.sv
// Frame-stable copy of the window and mode settings.
// Captures the live settings on the frame-start pulse. The eff_* outputs
// already show the new values in the capture clock, so the first line of a
// frame that begins together with the frame uses them.
// Assumes capture is a one-clock pulse.
module pm_roi_shadow #(
    parameter int CNT_W  = 12,
    parameter int BITS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CNT_W-1:0]  lines_in,
    input  logic [CNT_W-1:0]  pixels_in,
    input  logic [BITS_W-1:0] bits_in,
    input  logic [1:0]        mode_in,
    output logic [CNT_W-1:0]  eff_lines,
    output logic [CNT_W-1:0]  eff_pixels,
    output logic [BITS_W-1:0] eff_bits,
    output logic [1:0]        eff_mode
);

    logic [CNT_W-1:0]  sh_lines;
    logic [CNT_W-1:0]  sh_pixels;
    logic [BITS_W-1:0] sh_bits;
    logic [1:0]        sh_mode;

    // Latch the settings at frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lines  <= '0;
            sh_pixels <= '0;
            sh_bits   <= '0;
            sh_mode   <= '0;
        end else if (capture) begin
            sh_lines  <= lines_in;
            sh_pixels <= pixels_in;
            sh_bits   <= bits_in;
            sh_mode   <= mode_in;
        end
    end

    // Bypass the live values in the capture clock.
    always_comb begin
        eff_lines  = capture ? lines_in  : sh_lines;
        eff_pixels = capture ? pixels_in : sh_pixels;
        eff_bits   = capture ? bits_in   : sh_bits;
        eff_mode   = capture ? mode_in   : sh_mode;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(sh_lines) && $stable(sh_pixels) && $stable(sh_bits) && $stable(sh_mode))) // R10
        else $error("window settings changed outside frame start");

endmodule

// File: rtl/pm_position.sv
// Frame, line and pixel position tracking plus crop decisions.
// Finds frame and line starts from qualifier rising edges. Counts lines per
// frame and pixels per line, and decides how many pixels of the current
// clock fall inside the window.
// Assumes the limits are stable for a whole frame, as the shadow supplies them.
module pm_position #(
    parameter int CNT_W = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fval,
    input  logic             lval,
    input  logic             dval,
    input  logic [CNT_W-1:0] lim_lines,
    input  logic [CNT_W-1:0] lim_pixels,
    input  logic [1:0]       beat_px,
    output logic             frame_rise,
    output logic             fire,
    output logic [1:0]       take,
    output logic             sof,
    output logic             eol,
    output logic [IDX_W-1:0] line_nib
);

    logic             fval_q, lval_q, sof_pend;
    logic [CNT_W-1:0] line_cnt, line_idx_q, pix_cnt;
    logic             line_rise;
    logic [CNT_W-1:0] line_base, cur_line, pix_base, remaining;

    // Edge detection, position selection and crop decision.
    always_comb begin
        frame_rise = fval & ~fval_q;
        line_rise  = fval & lval & ~lval_q;
        line_base  = frame_rise ? '0 : line_cnt;
        cur_line   = line_rise ? line_base : line_idx_q;
        pix_base   = line_rise ? '0 : pix_cnt;
        remaining  = lim_pixels - pix_base;
        take       = (remaining < CNT_W'(beat_px)) ? remaining[1:0] : beat_px;
        fire       = fval & lval & dval & (cur_line < lim_lines) & (pix_base < lim_pixels);
        eol        = fire & ((pix_base + CNT_W'(take)) == lim_pixels);
        sof        = fire & (frame_rise | sof_pend);
        line_nib   = cur_line[IDX_W-1:0];
    end

    // Track qualifier history, counters and the pending start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval_q     <= 1'b0;
            lval_q     <= 1'b0;
            sof_pend   <= 1'b0;
            line_cnt   <= '0;
            line_idx_q <= '0;
            pix_cnt    <= '0;
        end else begin
            fval_q     <= fval;
            lval_q     <= lval;
            sof_pend   <= (frame_rise | sof_pend) & ~fire;
            line_idx_q <= cur_line;
            pix_cnt    <= fire ? pix_base + CNT_W'(take) : pix_base;
            if (line_rise)
                line_cnt <= line_base + 1'b1;
            else if (frame_rise)
                line_cnt <= '0;
        end
    end

    AST_EOL_ENDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> (!fire || (lval && !lval_q))) // R8
        else $error("pixels emitted after end of line");

endmodule

// File: rtl/pm_pack.sv
// Combinational pixel packer.
// Splits the port into pixels by mode, masks each to its significant bits,
// and zeroes lanes past the number of pixels kept.
// Assumes take is at least 1 whenever the result is used.
module pm_pack
    import pm_pkg::*;
#(
    parameter int BITS_W = 5
) (
    input  logic [1:0]        mode,
    input  logic [BITS_W-1:0] bits,
    input  logic [1:0]        take,
    input  logic [PORT_W-1:0] port,
    output logic [PORT_W-1:0] data
);

    logic [LANE_W-1:0]   mask8;
    logic [2*LANE_W-1:0] mask16;
    logic [PORT_W-1:0]   lane_data;

    // Per-width significant-bit masks.
    always_comb begin
        mask8  = (bits >= BITS_W'(LANE_W))   ? '1 : LANE_W'((16'd1 << bits) - 16'd1);
        mask16 = (bits >= BITS_W'(2*LANE_W)) ? '1 : (2*LANE_W)'((32'd1 << bits) - 32'd1);
    end

    // One masked, enabled slice per 8-bit lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lane_data[i*LANE_W +: LANE_W] =
                (2'(i) < take) ? (port[i*LANE_W +: LANE_W] & mask8) : '0;
        end
    end

    // Select the wide pixel or the lane layout.
    always_comb begin
        if (mode == PM_ONE16)
            data = {{(PORT_W-2*LANE_W){1'b0}}, port[2*LANE_W-1:0] & mask16};
        else
            data = lane_data;
    end

endmodule

// File: rtl/pix_mapper.sv
// Camera pixel mapper top.
// Turns qualified port data into cropped, masked pixel words with frame and
// line markers. Output is registered, one clock behind the input.
// Word layout: [23:0] pixels, [24] start of frame, [25] end of line,
// [27:26] pixel count, [31:28] line index low nibble.
module pix_mapper
    import pm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int BITS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       port_data,
    input  logic              fval,
    input  logic              lval,
    input  logic              dval,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  roi_lines,
    input  logic [CNT_W-1:0]  roi_pixels,
    input  logic [BITS_W-1:0] roi_bits,
    output logic              out_valid,
    output logic [31:0]       out_word
);

    localparam int IDX_W = WORD_W - PORT_W - 4;

    logic              frame_rise, fire, sof, eol;
    logic [1:0]        take, eff_mode;
    logic [IDX_W-1:0]  line_nib;
    logic [CNT_W-1:0]  eff_lines, eff_pixels;
    logic [BITS_W-1:0] eff_bits;
    logic [PORT_W-1:0] packed_px;

    pm_roi_shadow #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .capture(frame_rise),
        .lines_in(roi_lines), .pixels_in(roi_pixels),
        .bits_in(roi_bits), .mode_in(cfg_mode),
        .eff_lines(eff_lines), .eff_pixels(eff_pixels),
        .eff_bits(eff_bits), .eff_mode(eff_mode)
    );

    pm_position #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .fval(fval), .lval(lval), .dval(dval),
        .lim_lines(eff_lines), .lim_pixels(eff_pixels),
        .beat_px(beat_pixels(eff_mode)),
        .frame_rise(frame_rise), .fire(fire), .take(take),
        .sof(sof), .eol(eol), .line_nib(line_nib)
    );

    pm_pack #(.BITS_W(BITS_W)) u_pack (
        .mode(eff_mode), .bits(eff_bits), .take(take),
        .port(port_data), .data(packed_px)
    );

    // Register the assembled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= fire;
            if (fire)
                out_word <= {line_nib, take, eol, sof, packed_px};
        end
    end

    AST_VALID_NEEDS_QUALS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fval && lval && dval)) // R2
        else $error("word without qualifiers");

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[27:26] != 2'd0)) // R3
        else $error("empty word");

    AST_SINGLE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[27:26] == 2'd1) |-> (out_word[23:16] == 8'd0)) // R3
        else $error("upper lane set in single-pixel word");

    AST_SOF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(frame_rise)) |-> out_word[24]) // R7
        else $error("frame-start word missing flag");

endmodule

// File: tb/tb_pix_mapper.sv
// Bench: table of layout vectors, then directed crop, marker and reset tests.
module tb_pix_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] port_data = '0;
    logic        fval = 1'b0, lval = 1'b0, dval = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [11:0] roi_lines = '0, roi_pixels = '0;
    logic [4:0]  roi_bits = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_mapper dut (
        .clk(clk), .rst_n(rst_n), .port_data(port_data),
        .fval(fval), .lval(lval), .dval(dval), .cfg_mode(cfg_mode),
        .roi_lines(roi_lines), .roi_pixels(roi_pixels), .roi_bits(roi_bits),
        .out_valid(out_valid), .out_word(out_word)
    );

    // {mode, bits, port, expected word}; one-clock frames, R3 and R4.
    localparam logic [62:0] VEC [8] = '{
        {2'd0, 5'd8,  24'hABCDEF, 32'h050000EF},
        {2'd1, 5'd8,  24'hABCDEF, 32'h0900CDEF},
        {2'd2, 5'd8,  24'hABCDEF, 32'h0DABCDEF},
        {2'd3, 5'd16, 24'hABCDEF, 32'h0500CDEF},
        {2'd3, 5'd12, 24'hABCDEF, 32'h05000DEF},
        {2'd2, 5'd4,  24'hABCDEF, 32'h0D0B0D0F},
        {2'd0, 5'd0,  24'hABCDEF, 32'h05000000},
        {2'd1, 5'd20, 24'hABCDEF, 32'h0900CDEF}
    };

    task automatic chk(input string req, input bit ok, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expect a word: compares {valid, word}.
    task automatic want(input string req, input logic [31:0] exp);
        chk(req, out_valid === 1'b1 && out_word === exp, {out_valid, out_word}, {1'b1, exp});
    endtask

    task automatic none(input string req);
        chk(req, out_valid === 1'b0, {32'd0, out_valid}, 33'd0);
    endtask

    // Drive one clock of input at the falling edge, then sample after the rising edge.
    task automatic beat(input logic f, input logic l, input logic d, input logic [23:0] p);
        @(negedge clk);
        fval = f; lval = l; dval = d; port_data = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        beat(0, 0, 0, 0);
        beat(1, 1, 1, 24'h123456);
        none("R1 in reset");
        chk("R1 word in reset", out_word === 32'd0, {1'b0, out_word}, 33'd0);
        beat(0, 0, 0, 0);
        rst_n = 1'b1;
        beat(0, 0, 0, 0);
        none("R1 after reset");
        chk("R1 word after reset", out_word === 32'd0, {1'b0, out_word}, 33'd0);

        // Layout table walk: R3, R4.
        roi_lines = 12'd4; roi_pixels = 12'd100;
        for (int i = 0; i < 8; i++) begin
            cfg_mode = VEC[i][62:61];
            roi_bits = VEC[i][60:56];
            beat(1, 1, 1, VEC[i][55:32]);
            want("R3/R4 layout vector", VEC[i][31:0]);
            beat(0, 0, 0, 0);
        end

        // Data gaps and qualifiers: R2, R7.
        cfg_mode = 2'd0; roi_bits = 5'd8;
        beat(1, 1, 0, 24'h000011);
        none("R2 dval low");
        beat(1, 1, 1, 24'h000022);
        want("R7 sof after gap", 32'h05000022);
        beat(1, 1, 1, 24'h000033);
        want("R7 sof only once", 32'h04000033);
        beat(1, 0, 1, 24'h000044);
        none("R2 lval low");
        beat(0, 0, 1, 24'h000055);
        none("R2 fval low");

        // Crop, line markers, deferred settings: R5, R6, R8, R9, R10, R11.
        cfg_mode = 2'd2; roi_pixels = 12'd4; roi_lines = 12'd2;
        beat(1, 1, 1, 24'h030201);
        want("R5 first beat full", 32'h0D030201);
        beat(1, 1, 1, 24'h060504);
        want("R8 straddle eol", 32'h06000004);
        beat(1, 1, 1, 24'h090807);
        none("R5 past pixel limit");
        roi_pixels = 12'd1; cfg_mode = 2'd0;
        beat(1, 0, 1, 24'h0);
        none("R2 between lines");
        beat(1, 1, 1, 24'h0C0B0A);
        want("R9 R11 R10 second line", 32'h1C0C0B0A);
        beat(1, 1, 1, 24'h0F0E0D);
        want("R8 second line eol", 32'h1600000D);
        beat(1, 0, 0, 0);
        beat(1, 1, 1, 24'h777777);
        none("R6 line beyond limit");
        beat(0, 0, 0, 0);
        beat(1, 1, 1, 24'h0000AB);
        want("R10 R11 new frame settings", 32'h070000AB);
        beat(1, 1, 1, 24'h0000CD);
        none("R5 one pixel per line");

        // Reset in mid frame: R1.
        @(negedge clk);
        rst_n = 1'b0;
        beat(1, 1, 1, 24'h0000EE);
        none("R1 reset mid frame");
        rst_n = 1'b1;
        beat(0, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule